// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block watches for a software heartbeat against a free-running timebase count supplied from outside. Once enabled, it waits a programmed number of timebase ticks. If no refresh arrives in that time it raises a warning level, which is meant to drive an interrupt. It then waits the same interval again. If there is still no refresh, it raises a reset request. The reset request holds until the block itself is reset.

Software reaches the block through two register windows on a simple memory-mapped bus, with one select line per window. The refresh window holds a single register. Any write to that register re-arms the timer, whatever the data. The control window holds these registers:

- an enable/status word;
- a 32-bit interval (offset) register;
- a compare register as wide as the timebase, split into a low word and a high word;
- two identification words, which are also visible in the refresh window.

A write to the enable/status word also counts as a refresh. Writing zero to it stops the watchdog. Enabling with an interval of zero makes both stages fire almost at once, so software can use it to force a reset.

Top module: `wdog_escalate`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the following all read zero: the enable/status word, the interval register and the compare register. Both warn_irq and sys_reset_req are low.
- R2: A write to control-window address 0x000 or refresh-window address 0x000 is a refresh, whatever the write data. A refresh loads the compare register with (timebase count at that edge + interval) and clears both status bits.
- R3: At control-window address 0x000, bit 0 is the enable, bit 1 is the warning status and bit 2 is the reset status; the other bits read 0. A write there sets the enable from data bit 0 and also refreshes.
- R4: Control-window address 0x008 holds the 32-bit interval register. Address 0x010 holds compare bits 31:0 and address 0x014 holds compare bits 47:32, zero-extended. All three can be written and read back.
- R5: While enabled, when the count is at or above the compare value and the warning bit is clear, the block sets the warning bit, drives warn_irq high and reloads the compare register with (count + interval). If nothing refreshes, warn_irq first reads high at the edge where the count equals (refresh count + interval).
- R6: While enabled, when the count is at or above the compare value and the warning bit is already set, the block sets the reset status bit and drives sys_reset_req high. With no refresh, this happens at count (refresh count + 2 × interval).
- R7: While the enable is clear, neither status bit becomes set and warn_irq stays low, even after the count passes the compare value.
- R8: Once sys_reset_req is high, it stays high through refreshes and disables until rst_n is taken low.
- R9: Enabling with an interval of 0 at count C raises warn_irq at count C+1 and sys_reset_req at count C+2.
- R10: In both windows, address 0xFCC reads the IFACE_ID parameter and address 0xFD0 reads the PART_ID parameter. Unmapped addresses read 0. Writes to identification addresses and unmapped addresses change nothing and do not refresh.
- R11: bus_rdata carries the addressed value in the cycle after the edge that samples bus_rd_en. In all other cycles it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_count | input | 48 | Free-running timebase count |
| bus_ctrl_sel | input | 1 | Selects the control window |
| bus_rfsh_sel | input | 1 | Selects the refresh window |
| bus_wr_en | input | 1 | Write strobe, one cycle per access |
| bus_rd_en | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| warn_irq | output | 1 | First-stage warning level |
| sys_reset_req | output | 1 | Second-stage reset request, sticky |

## Verification
The assertions assume the following about the inputs:

- Only one window select is high in any cycle.
- A bus access never holds read and write together.
- The timebase moves by at most a few ticks per clock and does not wrap during a run.

Under those conditions, the compare reload seen one cycle after a refresh or a first-stage expiry equals the previous count plus the interval.

The bench keeps to these assumptions in how it drives the inputs:

- It advances the count by exactly one on each falling clock edge, starting from zero.
- It issues every access as a single-cycle strobe with exactly one select raised.
- It keeps intervals small, so that the compare value stays far below the 48-bit limit.

// File: rtl/wdog_escalate_pkg.sv
// Shared constants and types for the two-stage watchdog.
// Assumes byte offsets within a 4 KiB window; word accesses only.
package wdog_escalate_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_INTERVAL = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_RFSH     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_IFACE_ID = 12'hFCC;
    localparam logic [ADDR_W-1:0] OFS_PART_ID  = 12'hFD0;

    // Register targeted by the current bus access
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_INTERVAL,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_RFSH,
        SEL_IFACE_ID,
        SEL_PART_ID
    } reg_sel_e;
endpackage

// File: rtl/wdog_regif.sv
// Bus decode and readback for the two register windows.
// Produces one-cycle write strobes for the timer core and a registered
// read word. Assumes at most one window select is high per cycle
// (control wins if both are high) and read and write are not combined.
module wdog_regif
    import wdog_escalate_pkg::*;
#(
    parameter int          CNT_W    = 48,
    parameter int          OFS_W    = 32,
    parameter logic [31:0] IFACE_ID = 32'h5744_0001,
    parameter logic [31:0] PART_ID  = 32'h0000_2D57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_sel,
    input  logic              rfsh_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              st_en,
    input  logic              st_warn,
    input  logic              st_rst,
    input  logic [OFS_W-1:0]  st_interval,
    input  logic [CNT_W-1:0]  st_cmp,
    output logic              refresh_o,
    output logic              ctrl_wr_o,
    output logic              interval_wr_o,
    output logic              cmp_lo_wr_o,
    output logic              cmp_hi_wr_o,
    output logic [31:0]       rdata_o
);
    localparam int HI_W = CNT_W - 32;

    reg_sel_e    sel_now;
    logic [31:0] rd_value;

    // Map a window-relative address to a register
    function automatic reg_sel_e decode(input logic ctrl_win, input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        r = SEL_NONE;
        if (ctrl_win) begin
            case (a)
                OFS_CTRL:     r = SEL_CTRL;
                OFS_INTERVAL: r = SEL_INTERVAL;
                OFS_CMP_LO:   r = SEL_CMP_LO;
                OFS_CMP_HI:   r = SEL_CMP_HI;
                OFS_IFACE_ID: r = SEL_IFACE_ID;
                OFS_PART_ID:  r = SEL_PART_ID;
                default:      r = SEL_NONE;
            endcase
        end else begin
            case (a)
                OFS_RFSH:     r = SEL_RFSH;
                OFS_IFACE_ID: r = SEL_IFACE_ID;
                OFS_PART_ID:  r = SEL_PART_ID;
                default:      r = SEL_NONE;
            endcase
        end
        return r;
    endfunction

    // Pick the register addressed in this cycle
    always_comb begin
        if (ctrl_sel)      sel_now = decode(1'b1, addr);
        else if (rfsh_sel) sel_now = decode(1'b0, addr);
        else               sel_now = SEL_NONE;
    end

    // Write strobes; a control-word write doubles as a refresh
    always_comb begin
        ctrl_wr_o     = wr_en && (sel_now == SEL_CTRL);
        refresh_o     = wr_en && ((sel_now == SEL_CTRL) || (sel_now == SEL_RFSH));
        interval_wr_o = wr_en && (sel_now == SEL_INTERVAL);
        cmp_lo_wr_o   = wr_en && (sel_now == SEL_CMP_LO);
        cmp_hi_wr_o   = wr_en && (sel_now == SEL_CMP_HI);
    end

    // Read multiplexer
    always_comb begin
        case (sel_now)
            SEL_CTRL:     rd_value = {29'd0, st_rst, st_warn, st_en};
            SEL_INTERVAL: rd_value = 32'(st_interval);
            SEL_CMP_LO:   rd_value = st_cmp[31:0];
            SEL_CMP_HI:   rd_value = 32'(st_cmp[CNT_W-1:32]);
            SEL_IFACE_ID: rd_value = IFACE_ID;
            SEL_PART_ID:  rd_value = PART_ID;
            default:      rd_value = 32'd0;
        endcase
    end

    // Registered read data, zero outside read cycles
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_o <= 32'd0;
        else if (rd_en) rdata_o <= rd_value;
        else            rdata_o <= 32'd0;
    end

    // R10: at most one register receives a write in any cycle
    a_r10_one_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr_o, interval_wr_o, cmp_lo_wr_o, cmp_hi_wr_o}));

    // R11: an identification read returns the parameter on the next cycle
    a_r11_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctrl_sel && addr == OFS_PART_ID) |=> (rdata_o == PART_ID));

    // R11: no read strobe means zero read data next cycle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata_o == 32'd0));

    initial begin
        assert (HI_W >= 1 && HI_W <= 32);
    end
endmodule

// File: rtl/wdog_timer.sv
// Compare/escalation core of the watchdog. Holds the enable, interval,
// compare value, both status bits and the sticky reset request.
// Assumes the count input is monotonic and never wraps within a run;
// CNT_W lies in 33..64 and OFS_W is at most 32.
module wdog_timer #(
    parameter int CNT_W = 48,
    parameter int OFS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             refresh,
    input  logic             ctrl_wr,
    input  logic             interval_wr,
    input  logic             cmp_lo_wr,
    input  logic             cmp_hi_wr,
    input  logic [31:0]      wdata,
    output logic             en_o,
    output logic             warn_o,
    output logic             rst_st_o,
    output logic [OFS_W-1:0] interval_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             reset_req_o
);
    localparam int HI_W = CNT_W - 32;

    logic             hit;
    logic             cmp_wr_any;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cmp_next;

    // Expiry detect and next deadline
    always_comb begin
        hit        = en_o && (count >= cmp_o);
        reload     = count + CNT_W'(interval_o);
        cmp_wr_any = cmp_lo_wr || cmp_hi_wr;
    end

    // Next compare value: refresh, direct write, or first-stage reload
    always_comb begin
        cmp_next = cmp_o;
        if (cmp_lo_wr) cmp_next[31:0]      = wdata;
        if (cmp_hi_wr) cmp_next[CNT_W-1:32] = wdata[HI_W-1:0];
        if (refresh)
            cmp_next = reload;
        else if (hit && !warn_o && !cmp_wr_any)
            cmp_next = reload;
    end

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_o <= '0;
        else        cmp_o <= cmp_next;
    end

    // Enable bit, written through the control word
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= 1'b0;
        else if (ctrl_wr) en_o <= wdata[0];
    end

    // Interval register
    always_ff @(posedge clk) begin
        if (!rst_n)           interval_o <= '0;
        else if (interval_wr) interval_o <= wdata[OFS_W-1:0];
    end

    // Status bits: refresh clears, expiry escalates warning then reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_o   <= 1'b0;
            rst_st_o <= 1'b0;
        end else if (refresh) begin
            warn_o   <= 1'b0;
            rst_st_o <= 1'b0;
        end else if (hit) begin
            if (!warn_o) warn_o   <= 1'b1;
            else         rst_st_o <= 1'b1;
        end
    end

    // Sticky reset request, cleared only by block reset
    always_ff @(posedge clk) begin
        if (!rst_n)                        reset_req_o <= 1'b0;
        else if (hit && warn_o && !refresh) reset_req_o <= 1'b1;
    end

    // R7: a disabled watchdog carries no status
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> (!warn_o && !rst_st_o));

    // R2: refresh clears status and re-arms from count plus interval
    a_r2_refresh_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (!warn_o && !rst_st_o &&
                     cmp_o == $past(count) + CNT_W'($past(interval_o))));

    // R5: first-stage expiry reloads the deadline
    a_r5_warn_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(warn_o) && !$past(cmp_wr_any)) |->
            (cmp_o == $past(count) + CNT_W'($past(interval_o))));

    // R6: reset stage only follows a standing warning
    a_r6_escalate_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_st_o) |-> (warn_o && $past(warn_o)));

    // R8: reset request is sticky
    a_r8_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> reset_req_o);
endmodule

// File: rtl/wdog_escalate.sv
// Top of the two-stage watchdog: bus decode plus timer core.
// Assumes tick_count is a free-running timebase sampled on clk.
module wdog_escalate
    import wdog_escalate_pkg::*;
#(
    parameter int          CNT_W    = 48,
    parameter int          OFS_W    = 32,
    parameter logic [31:0] IFACE_ID = 32'h5744_0001,
    parameter logic [31:0] PART_ID  = 32'h0000_2D57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tick_count,
    input  logic              bus_ctrl_sel,
    input  logic              bus_rfsh_sel,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              warn_irq,
    output logic              sys_reset_req
);
    logic             refresh, ctrl_wr, interval_wr, cmp_lo_wr, cmp_hi_wr;
    logic             st_en, st_warn, st_rst;
    logic [OFS_W-1:0] st_interval;
    logic [CNT_W-1:0] st_cmp;

    wdog_regif #(
        .CNT_W(CNT_W), .OFS_W(OFS_W), .IFACE_ID(IFACE_ID), .PART_ID(PART_ID)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .ctrl_sel(bus_ctrl_sel), .rfsh_sel(bus_rfsh_sel),
        .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
        .st_en(st_en), .st_warn(st_warn), .st_rst(st_rst),
        .st_interval(st_interval), .st_cmp(st_cmp),
        .refresh_o(refresh), .ctrl_wr_o(ctrl_wr), .interval_wr_o(interval_wr),
        .cmp_lo_wr_o(cmp_lo_wr), .cmp_hi_wr_o(cmp_hi_wr),
        .rdata_o(bus_rdata)
    );

    wdog_timer #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .count(tick_count),
        .refresh(refresh), .ctrl_wr(ctrl_wr), .interval_wr(interval_wr),
        .cmp_lo_wr(cmp_lo_wr), .cmp_hi_wr(cmp_hi_wr), .wdata(bus_wdata),
        .en_o(st_en), .warn_o(st_warn), .rst_st_o(st_rst),
        .interval_o(st_interval), .cmp_o(st_cmp),
        .reset_req_o(sys_reset_req)
    );

    assign warn_irq = st_warn;

    // R1: outputs are low right after a block reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!warn_irq && !sys_reset_req && bus_rdata == 32'd0));
endmodule

// File: tb/tb_wdog_escalate.sv
// Directed bench: one task per scenario. Timebase advances on falling
// edges; all sampling happens 2 time units after a rising edge.
module tb_wdog_escalate;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IFACE_ID = 32'h5744_0001;
    localparam logic [31:0] PART_ID  = 32'h0000_2D57;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] tcount = '0;
    logic        ctrl_sel = 1'b0, rfsh_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        warn_irq, sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [47:0] last_cnt;

    wdog_escalate dut (
        .clk(clk), .rst_n(rst_n), .tick_count(tcount),
        .bus_ctrl_sel(ctrl_sel), .bus_rfsh_sel(rfsh_sel),
        .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata),
        .warn_irq(warn_irq), .sys_reset_req(sys_reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tcount <= tcount + 48'd1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2; rst_n = 1'b1;
    endtask

    task automatic bus_write(input bit ctrl_win, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        ctrl_sel = ctrl_win; rfsh_sel = !ctrl_win; wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        last_cnt = tcount;
        ctrl_sel = 1'b0; rfsh_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(input bit ctrl_win, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        ctrl_sel = ctrl_win; rfsh_sel = !ctrl_win; rd_en = 1'b1; addr = a;
        @(posedge clk); #2;
        d = rdata;
        ctrl_sel = 1'b0; rfsh_sel = 1'b0; rd_en = 1'b0;
    endtask

    // Wait for warn (which=0) or reset request (which=1); report count at that edge
    task automatic wait_level(input bit which, input int lim, output bit seen, output logic [47:0] at);
        seen = 1'b0; at = '0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(posedge clk); #2;
            if ((which ? sys_reset_req : warn_irq) === 1'b1) begin
                seen = 1'b1; at = tcount;
            end
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        check(warn_irq === 1'b0, "R1 warn low", 64'(warn_irq), 0);
        check(sys_reset_req === 1'b0, "R1 reset low", 64'(sys_reset_req), 0);
        check(rdata === 32'd0, "R11 idle rdata", 64'(rdata), 0);
        bus_read(1, 12'h000, d); check(d === 32'd0, "R1 ctrl word", 64'(d), 0);
        bus_read(1, 12'h008, d); check(d === 32'd0, "R1 interval", 64'(d), 0);
        bus_read(1, 12'h010, d); check(d === 32'd0, "R1 compare", 64'(d), 0);
    endtask

    task automatic t_registers();
        logic [31:0] d;
        bus_write(1, 12'h008, 32'h1234_5678);
        bus_read(1, 12'h008, d); check(d === 32'h1234_5678, "R4 interval rw", 64'(d), 64'h1234_5678);
        bus_write(1, 12'h010, 32'hCAFE_0001);
        bus_write(1, 12'h014, 32'h0000_00AB);
        bus_read(1, 12'h010, d); check(d === 32'hCAFE_0001, "R4 cmp lo rw", 64'(d), 64'hCAFE_0001);
        bus_read(1, 12'h014, d); check(d === 32'h0000_00AB, "R4 cmp hi rw", 64'(d), 64'hAB);
        bus_write(1, 12'h014, 32'hFFFF_FFFF);
        bus_read(1, 12'h014, d); check(d === 32'h0000_FFFF, "R4 cmp hi 16 bits", 64'(d), 64'hFFFF);
        bus_read(1, 12'hFCC, d); check(d === IFACE_ID, "R10 ctrl iface id", 64'(d), 64'(IFACE_ID));
        bus_read(1, 12'hFD0, d); check(d === PART_ID, "R10 ctrl part id", 64'(d), 64'(PART_ID));
        bus_read(0, 12'hFCC, d); check(d === IFACE_ID, "R10 rfsh iface id", 64'(d), 64'(IFACE_ID));
        bus_read(0, 12'hFD0, d); check(d === PART_ID, "R10 rfsh part id", 64'(d), 64'(PART_ID));
        bus_read(1, 12'h020, d); check(d === 32'd0, "R10 unmapped zero", 64'(d), 0);
        bus_write(1, 12'hFCC, 32'h0);
        bus_read(1, 12'hFCC, d); check(d === IFACE_ID, "R10 id write ignored", 64'(d), 64'(IFACE_ID));
        @(posedge clk); #2;
        check(rdata === 32'd0, "R11 rdata zero after read", 64'(rdata), 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        logic [47:0] c;
        do_reset();
        bus_write(1, 12'h008, 32'd5);
        bus_write(0, 12'h000, 32'h0BAD_F00D);
        c = last_cnt + 48'd5;
        bus_read(1, 12'h010, d); check(d === c[31:0], "R2 refresh loads compare", 64'(d), 64'(c[31:0]));
        repeat (20) @(posedge clk);
        #2;
        check(warn_irq === 1'b0, "R7 no warn while disabled", 64'(warn_irq), 0);
        bus_read(1, 12'h000, d); check(d === 32'd0, "R7 no status while disabled", 64'(d), 0);
    endtask

    task automatic t_two_stage();
        logic [31:0] d;
        logic [47:0] c0, at;
        bit seen;
        do_reset();
        bus_write(1, 12'h008, 32'd6);
        bus_write(1, 12'h000, 32'h1);
        c0 = last_cnt;
        wait_level(0, 40, seen, at);
        check(seen && at == c0 + 48'd6, "R5 warn time", 64'(at), 64'(c0 + 48'd6));
        check(sys_reset_req === 1'b0, "R6 reset not yet", 64'(sys_reset_req), 0);
        wait_level(1, 40, seen, at);
        check(seen && at == c0 + 48'd12, "R6 reset time", 64'(at), 64'(c0 + 48'd12));
        bus_read(1, 12'h000, d); check(d === 32'd7, "R3 status bits", 64'(d), 7);
        bus_read(1, 12'h010, d); check(d === 32'(c0 + 48'd12), "R5 compare reloaded", 64'(d), 64'(c0 + 48'd12));
        bus_write(1, 12'h000, 32'h0);
        bus_read(1, 12'h000, d); check(d === 32'd0, "R3 disable clears", 64'(d), 0);
        check(warn_irq === 1'b0, "R3 warn cleared", 64'(warn_irq), 0);
        check(sys_reset_req === 1'b1, "R8 reset sticky", 64'(sys_reset_req), 1);
        do_reset();
        check(sys_reset_req === 1'b0, "R8 cleared by block reset", 64'(sys_reset_req), 0);
    endtask

    task automatic t_refresh_holdoff();
        logic [47:0] c0, at;
        bit seen;
        do_reset();
        bus_write(1, 12'h008, 32'd10);
        bus_write(1, 12'h000, 32'h1);
        for (int i = 0; i < 6; i++) begin
            repeat (4) @(posedge clk);
            bus_write(0, 12'h000, 32'hDEAD_0000 + 32'(i));
        end
        check(warn_irq === 1'b0, "R2 refreshes hold off warn", 64'(warn_irq), 0);
        bus_write(0, 12'h000, 32'h0);
        c0 = last_cnt;
        bus_write(0, 12'h008, 32'h1);
        wait_level(0, 40, seen, at);
        check(seen && at == c0 + 48'd10, "R10 off-map refresh write ignored", 64'(at), 64'(c0 + 48'd10));
        bus_write(1, 12'h000, 32'h0);
    endtask

    task automatic t_zero_interval();
        logic [47:0] c0, at;
        bit seen;
        do_reset();
        bus_write(1, 12'h000, 32'h1);
        c0 = last_cnt;
        wait_level(0, 10, seen, at);
        check(seen && at == c0 + 48'd1, "R9 immediate warn", 64'(at), 64'(c0 + 48'd1));
        wait_level(1, 10, seen, at);
        check(seen && at == c0 + 48'd2, "R9 immediate reset", 64'(at), 64'(c0 + 48'd2));
    endtask

    initial begin
        t_reset_state();
        t_registers();
        t_disabled();
        t_two_stage();
        t_refresh_holdoff();
        t_zero_interval();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule